// File: doc/BRIEF.md
# Framed Serial Command Packet Decoder

This block sits behind a serial bit decoder and builds command packets from the bits it gets. Each accepted bit comes with a strobe. The bits are shifted into a word of 38 positions. Once the 38th bit of a packet has arrived, the block checks three fixed marker fields: a leading start marker, a two-bit guard pair in the middle of the word, and a trailing end marker. The values of these markers are chosen so that no payload value can look like a marker.

If all three markers match, the block puts out a single-cycle command strobe together with a two-bit function code, a two-bit parameter select and an eight-bit value. If any marker is wrong, it puts out a single-cycle framing-error strobe instead. In both cases the bit counter goes back to zero and the next bit starts a new packet. When the bit decoder reports an error partway through a packet, the partial word is thrown away.

Function codes: 00 adjust sense current, 01 try value, 10 burn value, 11 read back value. Parameter selects: 00 second-stage gain, 01 first-stage gain, 10 output offset, 11 miscellaneous. This block only delivers these codes; it does not carry out the command.

Top module: `framed_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, `cmd_vld` and `frame_err` are 0, the three field outputs are 0, and no partial packet is held.
- R2: The first bit received is word bit 37 and each later bit takes the next lower index. The fields are: start [37:26], function [25:24], parameter [23:22], guard [21:20], value [19:12], end [11:0]. Each field therefore arrives most significant bit first.
- R3: A packet whose start is 12'h801, guard is 2'b10 and end is 12'h7FE raises `cmd_vld` for exactly one cycle. The pulse appears in the cycle after the clock edge that samples the 38th bit. In that same cycle `cmd_func`, `cmd_param` and `cmd_value` carry the packet's fields.
- R4: A packet whose start field is not 12'h801 raises `frame_err` for one cycle at the R3 timing and does not raise `cmd_vld`.
- R5: A packet whose guard field is not 2'b10 raises `frame_err` for one cycle and does not raise `cmd_vld`.
- R6: A packet whose end field is not 12'h7FE raises `frame_err` for one cycle and does not raise `cmd_vld`.
- R7: After the 38th bit, the bit count starts again at zero, so a packet may begin on the very next accepted bit (back-to-back packets).
- R8: A cycle with `bit_err` high discards the partial word. The next 38 accepted bits are decoded as a new packet.
- R9: `bit_err` takes priority over `bit_vld` in the same cycle. If it coincides with what would be the 38th bit, neither `cmd_vld` nor `frame_err` pulses and the word is dropped.
- R10: The field outputs change only together with a `cmd_vld` pulse. They keep the last accepted command across framing errors and discarded packets.
- R11: Cycles with `bit_vld` low change no state. Bits may be spaced by any number of idle cycles.
- R12: `cmd_vld` and `frame_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (external power-on reset) |
| bit_vld | input | 1 | Strobe: `bit_val` holds a decoded bit |
| bit_val | input | 1 | Decoded bit value |
| bit_err | input | 1 | Bit decoder error; discards the partial packet |
| cmd_vld | output | 1 | One-cycle strobe for a correctly framed command |
| cmd_func | output | 2 | Function code of the last accepted command |
| cmd_param | output | 2 | Parameter select of the last accepted command |
| cmd_value | output | 8 | Value of the last accepted command |
| frame_err | output | 1 | One-cycle strobe for a packet with a marker mismatch |

## Verification
Two events can land on the same clock edge. One is the completion of a packet, where the 38th bit triggers the framing decision. The other is a bit-decoder error that should throw the packet away. The bench raises `bit_err` exactly on the 38th strobe of an otherwise correct packet, and separately raises it partway through a packet. A behavioural queue model, compared every clock, expects neither strobe for the aborted word, expects the command fields to stay unchanged, and expects the following clean packet to decode normally. Back-to-back packets, where a new first bit directly follows a completion, exercise the counter restart in the same way.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

   // Field widths of one command packet
   localparam int START_W = 12;
   localparam int FUNC_W  = 2;
   localparam int PARAM_W = 2;
   localparam int GUARD_W = 2;
   localparam int VALUE_W = 8;
   localparam int END_W   = 12;

   // Marker values
   localparam logic [START_W-1:0] START_CODE = 12'h801;
   localparam logic [GUARD_W-1:0] GUARD_CODE = 2'b10;
   localparam logic [END_W-1:0]   END_CODE   = 12'h7FE;

   // Total packet length for a given set of field widths
   function automatic int word_width(input int sw, input int fw, input int pw,
                                     input int gw, input int vw, input int ew);
      return sw + fw + pw + gw + vw + ew;
   endfunction

endpackage

// File: rtl/fcd_marker_cmp.sv
// Compares one marker field against its constant, bit by bit.
module fcd_marker_cmp #(
   parameter int            W    = 12,
   parameter logic [W-1:0]  CODE = '0
) (
   input  logic [W-1:0] field,
   output logic         hit
);
   logic [W-1:0] diff;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign diff[i] = field[i] ^ CODE[i];
   end

   assign hit = ~|diff;
endmodule

// File: rtl/fcd_bit_counter.sv
// Counts accepted bits within a packet; flags the final bit position.
module fcd_bit_counter #(
   parameter int WORD_W = 38,
   localparam int CNT_W = $clog2(WORD_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_en,
   input  logic flush,
   output logic last_bit
);
   logic [CNT_W-1:0] count_q;

   assign last_bit = (count_q == CNT_W'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count_q <= '0;
      else if (flush)    count_q <= '0;
      else if (shift_en) count_q <= count_q + 1'b1;
   end
endmodule

// File: rtl/fcd_shift_reg.sv
// Holds the first WORD_W-1 bits. The final bit is never stored:
// it is joined combinationally into word_next for the framing check.
module fcd_shift_reg #(
   parameter int WORD_W = 38
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              flush,
   input  logic              din,
   output logic [WORD_W-1:0] word_next
);
   logic [WORD_W-2:0] hold_q;

   assign word_next = {hold_q, din};

   generate
      if (WORD_W > 2) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hold_q <= '0;
            else if (flush)    hold_q <= '0;
            else if (shift_en) hold_q <= {hold_q[WORD_W-3:0], din};
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        hold_q <= '0;
            else if (flush)    hold_q <= '0;
            else if (shift_en) hold_q <= din;
         end
      end
   endgenerate
endmodule

// File: rtl/fcd_frame_check.sv
// Splits a complete word into fields and checks the three markers.
module fcd_frame_check #(
   parameter int START_W = 12,
   parameter int FUNC_W  = 2,
   parameter int PARAM_W = 2,
   parameter int GUARD_W = 2,
   parameter int VALUE_W = 8,
   parameter int END_W   = 12,
   parameter logic [START_W-1:0] START_CODE = '0,
   parameter logic [GUARD_W-1:0] GUARD_CODE = '0,
   parameter logic [END_W-1:0]   END_CODE   = '0,
   localparam int VALUE_LSB = END_W,
   localparam int GUARD_LSB = VALUE_LSB + VALUE_W,
   localparam int PARAM_LSB = GUARD_LSB + GUARD_W,
   localparam int FUNC_LSB  = PARAM_LSB + PARAM_W,
   localparam int START_LSB = FUNC_LSB + FUNC_W,
   localparam int WORD_W    = START_LSB + START_W
) (
   input  logic [WORD_W-1:0]  word,
   output logic               frame_ok,
   output logic [FUNC_W-1:0]  func,
   output logic [PARAM_W-1:0] param,
   output logic [VALUE_W-1:0] value
);
   logic start_hit, guard_hit, end_hit;

   fcd_marker_cmp #(.W(START_W), .CODE(START_CODE)) start_cmp_i (
      .field (word[START_LSB +: START_W]),
      .hit   (start_hit)
   );

   fcd_marker_cmp #(.W(GUARD_W), .CODE(GUARD_CODE)) guard_cmp_i (
      .field (word[GUARD_LSB +: GUARD_W]),
      .hit   (guard_hit)
   );

   fcd_marker_cmp #(.W(END_W), .CODE(END_CODE)) end_cmp_i (
      .field (word[0 +: END_W]),
      .hit   (end_hit)
   );

   assign frame_ok = start_hit & guard_hit & end_hit;
   assign func     = word[FUNC_LSB  +: FUNC_W];
   assign param    = word[PARAM_LSB +: PARAM_W];
   assign value    = word[VALUE_LSB +: VALUE_W];
endmodule

// File: rtl/framed_cmd_decoder.sv
module framed_cmd_decoder #(
   parameter int START_W = fcd_pkg::START_W,
   parameter int FUNC_W  = fcd_pkg::FUNC_W,
   parameter int PARAM_W = fcd_pkg::PARAM_W,
   parameter int GUARD_W = fcd_pkg::GUARD_W,
   parameter int VALUE_W = fcd_pkg::VALUE_W,
   parameter int END_W   = fcd_pkg::END_W,
   parameter logic [START_W-1:0] START_CODE = fcd_pkg::START_CODE,
   parameter logic [GUARD_W-1:0] GUARD_CODE = fcd_pkg::GUARD_CODE,
   parameter logic [END_W-1:0]   END_CODE   = fcd_pkg::END_CODE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_vld,
   input  logic               bit_val,
   input  logic               bit_err,
   output logic               cmd_vld,
   output logic [FUNC_W-1:0]  cmd_func,
   output logic [PARAM_W-1:0] cmd_param,
   output logic [VALUE_W-1:0] cmd_value,
   output logic               frame_err
);
   localparam int WORD_W = fcd_pkg::word_width(START_W, FUNC_W, PARAM_W,
                                               GUARD_W, VALUE_W, END_W);

   // Elaboration-time parameter checks
   if (START_W < 2 || END_W < 2) begin : g_bad_marker_w
      $error("marker fields must be at least two bits wide");
   end
   if (FUNC_W < 1 || PARAM_W < 1 || VALUE_W < 1 || GUARD_W < 1) begin : g_bad_field_w
      $error("every field needs at least one bit");
   end
   if (START_W == END_W && START_CODE == END_CODE) begin : g_same_marker
      $error("start and end markers must differ");
   end

   logic               shift_en, last_bit, done, flush, frame_ok;
   logic [WORD_W-1:0]  word_next;
   logic [FUNC_W-1:0]  f_func;
   logic [PARAM_W-1:0] f_param;
   logic [VALUE_W-1:0] f_value;

   // Decoder error wins over a simultaneous bit strobe
   assign shift_en = bit_vld & ~bit_err;
   assign done     = shift_en & last_bit;
   assign flush    = bit_err | done;

   fcd_bit_counter #(.WORD_W(WORD_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .flush    (flush),
      .last_bit (last_bit)
   );

   fcd_shift_reg #(.WORD_W(WORD_W)) sr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .flush     (flush),
      .din       (bit_val),
      .word_next (word_next)
   );

   fcd_frame_check #(
      .START_W(START_W), .FUNC_W(FUNC_W), .PARAM_W(PARAM_W),
      .GUARD_W(GUARD_W), .VALUE_W(VALUE_W), .END_W(END_W),
      .START_CODE(START_CODE), .GUARD_CODE(GUARD_CODE), .END_CODE(END_CODE)
   ) chk_frame_i (
      .word     (word_next),
      .frame_ok (frame_ok),
      .func     (f_func),
      .param    (f_param),
      .value    (f_value)
   );

   // Result strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld   <= 1'b0;
         frame_err <= 1'b0;
      end else begin
         cmd_vld   <= done & frame_ok;
         frame_err <= done & ~frame_ok;
      end
   end

   // Command fields hold until the next accepted packet
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_func  <= '0;
         cmd_param <= '0;
         cmd_value <= '0;
      end else if (done & frame_ok) begin
         cmd_func  <= f_func;
         cmd_param <= f_param;
         cmd_value <= f_value;
      end
   end
endmodule

// File: rtl/fcd_decoder_chk.sv
module fcd_decoder_chk #(
   parameter int FUNC_W  = 2,
   parameter int PARAM_W = 2,
   parameter int VALUE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bit_vld,
   input logic               bit_err,
   input logic               cmd_vld,
   input logic               frame_err,
   input logic [FUNC_W-1:0]  cmd_func,
   input logic [PARAM_W-1:0] cmd_param,
   input logic [VALUE_W-1:0] cmd_value
);
   assert_one_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_vld && frame_err));

   assert_cmd_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |=> !cmd_vld);

   assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |=> !frame_err);

   assert_err_drops_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_err |=> (!cmd_vld && !frame_err));

   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> (!cmd_vld && !frame_err));

   assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |-> $stable({cmd_func, cmd_param, cmd_value}));
endmodule

bind framed_cmd_decoder fcd_decoder_chk #(
   .FUNC_W(FUNC_W), .PARAM_W(PARAM_W), .VALUE_W(VALUE_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_vld   (bit_vld),
   .bit_err   (bit_err),
   .cmd_vld   (cmd_vld),
   .frame_err (frame_err),
   .cmd_func  (cmd_func),
   .cmd_param (cmd_param),
   .cmd_value (cmd_value)
);

// File: tb/framed_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module framed_cmd_decoder_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_vld = 1'b0;
   logic       bit_val = 1'b0;
   logic       bit_err = 1'b0;
   logic       cmd_vld, frame_err;
   logic [1:0] cmd_func, cmd_param;
   logic [7:0] cmd_value;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   framed_cmd_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
      .bit_err(bit_err), .cmd_vld(cmd_vld), .cmd_func(cmd_func),
      .cmd_param(cmd_param), .cmd_value(cmd_value), .frame_err(frame_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   bit         q[$];
   logic       exp_vld, exp_err;
   logic [1:0] exp_func, exp_param;
   logic [7:0] exp_value;

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         exp_vld = 0; exp_err = 0;
         exp_func = 0; exp_param = 0; exp_value = 0;
      end else begin
         exp_vld = 0; exp_err = 0;
         if (bit_err) q.delete();
         else if (bit_vld) begin
            q.push_back(bit_val);
            if (q.size() == 38) begin
               logic [37:0] w;
               w = '0;
               foreach (q[i]) w = {w[36:0], q[i]};
               if (w[37:26] == 12'h801 && w[21:20] == 2'b10 && w[11:0] == 12'h7FE) begin
                  exp_vld = 1;
                  exp_func = w[25:24]; exp_param = w[23:22]; exp_value = w[19:12];
               end else exp_err = 1;
               q.delete();
            end
         end
      end
   end

   // Pulse tallies taken from the ports
   int n_vld = 0, n_err = 0;

   // Compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check(cur_req, "outputs vs model",
               {18'd0, cmd_vld, frame_err, cmd_func, cmd_param, cmd_value},
               {18'd0, exp_vld, exp_err, exp_func, exp_param, exp_value});
         check("R12", "strobes exclusive", 32'(cmd_vld & frame_err), 32'd0);
         n_vld += int'(cmd_vld);
         n_err += int'(frame_err);
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [37:0] mk(input logic [11:0] s, input logic [1:0] f,
                                      input logic [1:0] p, input logic [1:0] g,
                                      input logic [7:0] v, input logic [11:0] e);
      return {s, f, p, g, v, e};
   endfunction

   task automatic drive_bit(input logic v, input logic err);
      bit_vld = 1'b1; bit_val = v; bit_err = err;
      @(negedge clk);
      bit_vld = 1'b0; bit_err = 1'b0; bit_val = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // err_at < 0: no error; otherwise bit_err on that bit index (0 = first sent)
   task automatic send(input logic [37:0] w, input int gap, input int err_at);
      for (int k = 0; k < 38; k++) begin
         if (k == err_at) begin
            drive_bit(w[37-k], 1'b1);
            return;
         end
         drive_bit(w[37-k], 1'b0);
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic expect_counts(input string req, input int v0, input int e0,
                                input int dv, input int de);
      idle(2);
      check(req, "cmd_vld pulses", 32'(n_vld - v0), 32'(dv));
      check(req, "frame_err pulses", 32'(n_err - e0), 32'(de));
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      int v0, e0;
      idle(3);
      // R1: reset state
      check("R1", "reset strobes", {30'd0, cmd_vld, frame_err}, 32'd0);
      check("R1", "reset fields", {20'd0, cmd_func, cmd_param, cmd_value}, 32'd0);
      rst_n = 1'b1;
      idle(1);
      check("R1", "post-reset fields", {20'd0, cmd_func, cmd_param, cmd_value}, 32'd0);

      // R3 / R2: one good packet
      cur_req = "R3"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b10, 2'b01, 2'b10, 8'hA5, 12'h7FE), 0, -1);
      expect_counts("R3", v0, e0, 1, 0);
      check("R2", "value field order", {24'd0, cmd_value}, 32'hA5);
      check("R2", "func/param order", {28'd0, cmd_func, cmd_param}, 32'b1001);

      // R11 / R2: every function code, bits spaced by idle cycles
      cur_req = "R11"; v0 = n_vld; e0 = n_err;
      for (int f = 0; f < 4; f++) begin
         send(mk(12'h801, 2'(f), 2'(3 - f), 2'b10, 8'(8'h3C + f * 17), 12'h7FE), f, -1);
         idle(2);
         check("R2", "func code", {30'd0, cmd_func}, 32'(f));
      end
      expect_counts("R11", v0, e0, 4, 0);

      // R4: bad start
      cur_req = "R4"; v0 = n_vld; e0 = n_err;
      send(mk(12'h800, 2'b11, 2'b11, 2'b10, 8'h11, 12'h7FE), 0, -1);
      expect_counts("R4", v0, e0, 0, 1);
      check("R10", "fields held after bad start", {24'd0, cmd_value}, 32'(8'h3C + 3 * 17));

      // R5: bad guard, all three wrong values
      cur_req = "R5"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b00, 2'b00, 2'b01, 8'h22, 12'h7FE), 0, -1);
      send(mk(12'h801, 2'b00, 2'b00, 2'b11, 8'h22, 12'h7FE), 0, -1);
      send(mk(12'h801, 2'b00, 2'b00, 2'b00, 8'h22, 12'h7FE), 0, -1);
      expect_counts("R5", v0, e0, 0, 3);

      // R6: bad end
      cur_req = "R6"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b01, 2'b10, 2'b10, 8'h33, 12'h7FF), 0, -1);
      expect_counts("R6", v0, e0, 0, 1);
      check("R10", "fields held after bad end", {24'd0, cmd_value}, 32'(8'h3C + 3 * 17));

      // R7: back-to-back packets with marker-like payloads
      cur_req = "R7"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b11, 2'b11, 2'b10, 8'hFF, 12'h7FE), 0, -1);
      send(mk(12'h801, 2'b00, 2'b00, 2'b10, 8'h00, 12'h7FE), 0, -1);
      send(mk(12'h801, 2'b01, 2'b00, 2'b10, 8'h80, 12'h7FE), 0, -1);
      expect_counts("R7", v0, e0, 3, 0);
      check("R7", "last back-to-back value", {24'd0, cmd_value}, 32'h80);

      // R8: decoder error mid-packet, then a clean packet
      cur_req = "R8"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b10, 2'b10, 2'b10, 8'h5A, 12'h7FE), 0, 20);
      idle(3);
      send(mk(12'h801, 2'b10, 2'b10, 2'b10, 8'h69, 12'h7FE), 0, -1);
      expect_counts("R8", v0, e0, 1, 0);
      check("R8", "value after discard", {24'd0, cmd_value}, 32'h69);

      // R9: decoder error on the final bit of a good packet
      cur_req = "R9"; v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b01, 2'b01, 2'b10, 8'hC3, 12'h7FE), 0, 37);
      expect_counts("R9", v0, e0, 0, 0);
      check("R9", "fields untouched", {24'd0, cmd_value}, 32'h69);
      v0 = n_vld; e0 = n_err;
      send(mk(12'h801, 2'b01, 2'b01, 2'b10, 8'hC3, 12'h7FE), 1, -1);
      expect_counts("R9", v0, e0, 1, 0);
      check("R9", "value after aborted word", {24'd0, cmd_value}, 32'hC3);

      idle(3);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule